// File: doc/BRIEF.md
# Programmable Edge/Level Interrupt Request Latch

This block turns eight raw interrupt request lines into a vector of pending requests for a downstream priority resolver. Each line first passes through a two-flop synchronizer. Each line then runs in one of two trigger modes. One bit per line in a writable control register selects the mode, and no single global mode bit exists. In edge mode a request is captured on a low-to-high transition. It is held until the acknowledge port names that line's level. In level mode the pending bit tracks the synchronized line directly.

A second strobe samples the line named at the first acknowledge cycle. If that line has already gone inactive, the block reports a spurious request and substitutes the lowest-priority level, 7. Priority resolution, in-service tracking, vector generation and cascading are handled elsewhere.

Top module: `irq_trigger_latch`

## Requirements
- R1: After reset, `pending`, `mode_q`, `sample_valid`, `sample_spurious` and `sample_level_o` are all zero, so every line starts in edge mode.
- R2: A write with `mode_wr_en` high loads `mode_wr_data` into the control register, and the new value appears on `mode_q` after that clock edge. Without a write, `mode_q` holds. Bit i = 0 selects edge mode for line i, and bit i = 1 selects level mode.
- R3: In edge mode, a low-to-high change of `irq_in[i]` sets `pending[i]`. The bit is visible three clocks after the edge that first samples the new high value.
- R4: In edge mode, a line held high after its request has been acknowledged raises no new request until it goes low and rises again.
- R5: An acknowledge with `ack_valid` high and `ack_level` = i clears only the edge-mode `pending[i]` bit. Level i maps to bit i.
- R6: In level mode, `pending[i]` equals `irq_in[i]` as sampled two clocks earlier, and an acknowledge has no effect on it.
- R7: In level mode, a line still high after its level is acknowledged stays pending.
- R8: One clock after `sample_strobe`, `sample_valid` is high for one cycle. If the synchronized line at `sample_level` was high, `sample_spurious` is 0 and `sample_level_o` equals `sample_level`.
- R9: If the synchronized line at `sample_level` was low at the strobe, `sample_spurious` is 1 and `sample_level_o` is 7.
- R10: An edge detected in the same cycle as an acknowledge of the same level keeps the request set.
- R11: While a line is in level mode, no edge request is stored for it. After the line returns to edge mode, a line that is still high does not become pending until it rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Raw interrupt request lines |
| mode_wr_en | input | 1 | Control register write enable |
| mode_wr_data | input | 8 | Control register write data, one mode bit per line |
| mode_q | output | 8 | Current control register value |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| sample_strobe | input | 1 | First-acknowledge sample strobe |
| sample_level | input | 3 | Level to sample for activity |
| pending | output | 8 | Pending request vector |
| sample_valid | output | 1 | Sample result valid, one cycle |
| sample_spurious | output | 1 | Sampled line was inactive |
| sample_level_o | output | 3 | Confirmed level, or 7 if spurious |

## Verification
A stuck or stale edge latch appears on `pending` no more than three clocks after the input edge that should have set it. A missed clear appears on the cycle after the acknowledge. A wrong control register value shows on `mode_q` one clock after the write. It also shows on `pending` within two clocks, because the pending bits then follow the wrong source. A fault in the sample path is caught one clock after the strobe, through `sample_spurious` and `sample_level_o`. The bench compares every output on every cycle against a model built from the requirements, so any divergence is flagged within those few cycles.

// File: rtl/irq_latch_pkg.sv
// Package: shared defaults and the sample result record for the request latch.
// Assumes: the line count is a power of two, so a level code covers all lines.
package irq_latch_pkg;
    localparam int unsigned DEF_LINES  = 8;
    localparam int unsigned DEF_STAGES = 2;
    localparam int unsigned DEF_LVL_W  = $clog2(DEF_LINES);

    typedef struct packed {
        logic                 valid;
        logic                 spurious;
        logic [DEF_LVL_W-1:0] level;
    } sample_res_t;
endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous request lines.
// Assumes: STAGES >= 1; the output is the last stage, reset low.
module irq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage from the previous one (stage 0 from the pin).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_trigger_cell.sv
// Module: per-line trigger logic; edge latch with acknowledge clear, or level follow.
// Assumes: sync_in is already synchronous; level_mode comes from a registered control bit.
module irq_trigger_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic level_mode,
    input  logic ack_hit,
    output logic pend
);
    logic prev_q;
    logic edge_q;
    logic rise;

    assign rise = sync_in & ~prev_q;

    // Remember the synchronized line one clock back for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    // Edge request latch: set by a rise (wins over ack), cleared by ack, discarded in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          edge_q <= 1'b0;
        else if (level_mode) edge_q <= 1'b0;
        else if (rise)       edge_q <= 1'b1;
        else if (ack_hit)    edge_q <= 1'b0;
    end

    // Pending source selected by the line's trigger mode.
    always_comb begin
        pend = level_mode ? sync_in : edge_q;
    end
endmodule

// File: rtl/irq_sample_check.sv
// Module: first-acknowledge activity check; flags a vanished line as spurious.
// Assumes: a spurious result reports the highest level code (lowest priority).
module irq_sample_check #(
    parameter int unsigned LINES = 8,
    localparam int unsigned LVL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] sync_vec,
    input  logic             strobe,
    input  logic [LVL_W-1:0] level_in,
    output logic             res_valid,
    output logic             res_spurious,
    output logic [LVL_W-1:0] res_level
);
    localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(LINES - 1);

    logic line_active;

    assign line_active = sync_vec[level_in];

    // Register the sample verdict one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_spurious <= 1'b0;
            res_level    <= '0;
        end else if (strobe) begin
            res_valid    <= 1'b1;
            res_spurious <= ~line_active;
            res_level    <= line_active ? level_in : SPUR_LVL;
        end else begin
            res_valid    <= 1'b0;
            res_spurious <= 1'b0;
            res_level    <= '0;
        end
    end
endmodule

// File: rtl/irq_trigger_latch.sv
// Module: top of the programmable edge/level request latch.
// Assumes: all inputs synchronous to clk apart from irq_in, which is synchronized here.
module irq_trigger_latch #(
    parameter int unsigned LINES  = irq_latch_pkg::DEF_LINES,
    parameter int unsigned STAGES = irq_latch_pkg::DEF_STAGES,
    localparam int unsigned LVL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic             mode_wr_en,
    input  logic [LINES-1:0] mode_wr_data,
    output logic [LINES-1:0] mode_q,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             sample_strobe,
    input  logic [LVL_W-1:0] sample_level,
    output logic [LINES-1:0] pending,
    output logic             sample_valid,
    output logic             sample_spurious,
    output logic [LVL_W-1:0] sample_level_o
);
    logic [LINES-1:0] sync_vec;
    logic [LINES-1:0] ack_hit;

    // Trigger mode control register; a write lands on the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q <= '0;
        else if (mode_wr_en) mode_q <= mode_wr_data;
    end

    irq_sync #(.WIDTH(LINES), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (sync_vec)
    );

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            assign ack_hit[i] = ack_valid && (ack_level == LVL_W'(i));

            irq_trigger_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .sync_in    (sync_vec[i]),
                .level_mode (mode_q[i]),
                .ack_hit    (ack_hit[i]),
                .pend       (pending[i])
            );
        end
    endgenerate

    irq_sample_check #(.LINES(LINES)) u_sample (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_vec     (sync_vec),
        .strobe       (sample_strobe),
        .level_in     (sample_level),
        .res_valid    (sample_valid),
        .res_spurious (sample_spurious),
        .res_level    (sample_level_o)
    );
endmodule

// File: rtl/irq_latch_checker.sv
// Module: port-level property checker for irq_trigger_latch, attached by bind.
// Assumes: default two-stage synchronizer latency; checks wait a few cycles after reset.
module irq_latch_checker #(
    parameter int unsigned LINES = 8,
    localparam int unsigned LVL_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] irq_in,
    input logic             mode_wr_en,
    input logic [LINES-1:0] mode_wr_data,
    input logic [LINES-1:0] mode_q,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ack_level,
    input logic             sample_strobe,
    input logic [LVL_W-1:0] sample_level,
    input logic [LINES-1:0] pending,
    input logic             sample_valid,
    input logic             sample_spurious,
    input logic [LVL_W-1:0] sample_level_o
);
    logic [2:0]       warm_cnt;
    logic             warm;
    logic [LINES-1:0] irq_d1, irq_d2, irq_d3, irq_d4;
    logic [LINES-1:0] mode_d1;
    logic             strobe_d1;
    logic [LVL_W-1:0] lvl_d1;
    logic             ack_seen;

    assign warm = (warm_cnt == 3'd5);
    assign ack_seen = ack_valid;

    // Count cycles since reset so history registers are valid before use.
    always_ff @(posedge clk) begin
        if (!rst_n)     warm_cnt <= '0;
        else if (!warm) warm_cnt <= warm_cnt + 3'd1;
    end

    // History of port values used by the timing properties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_d1 <= '0; irq_d2 <= '0; irq_d3 <= '0; irq_d4 <= '0;
            mode_d1 <= '0; strobe_d1 <= 1'b0; lvl_d1 <= '0;
        end else begin
            irq_d1 <= irq_in; irq_d2 <= irq_d1; irq_d3 <= irq_d2; irq_d4 <= irq_d3;
            mode_d1 <= mode_q; strobe_d1 <= sample_strobe; lvl_d1 <= sample_level;
        end
    end

    AST_MODE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_wr_en) |-> mode_q == $past(mode_wr_data)); // R2

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$past(mode_wr_en) |-> $stable(mode_q)); // R2

    AST_SPUR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        sample_spurious |-> sample_valid && (sample_level_o == LVL_W'(LINES - 1))); // R9

    AST_SAMPLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        warm && strobe_d1 |-> sample_valid && (sample_spurious == !irq_d3[lvl_d1])); // R8

    AST_NO_IDLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !strobe_d1 |-> !sample_valid && !sample_spurious); // R8

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_chk
            AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                warm && $rose(pending[i]) && !mode_q[i] && !mode_d1[i]
                |-> irq_d3[i] && !irq_d4[i]); // R3

            AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
                warm && mode_q[i] |-> pending[i] == irq_d2[i]); // R6
        end
    endgenerate
endmodule

bind irq_trigger_latch irq_latch_checker #(.LINES(LINES)) u_chk (.*);

// File: tb/irq_trigger_latch_bench.sv
module irq_trigger_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in;
    logic       mode_wr_en;
    logic [7:0] mode_wr_data;
    logic [7:0] mode_q;
    logic       ack_valid;
    logic [2:0] ack_level;
    logic       sample_strobe;
    logic [2:0] sample_level;
    logic [7:0] pending;
    logic       sample_valid;
    logic       sample_spurious;
    logic [2:0] sample_level_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference state built from the requirements.
    logic [7:0] m_s1, m_s2, m_prev, m_edge, m_mode;
    logic       m_sv, m_sp;
    logic [2:0] m_sl;

    always #10 clk = ~clk;

    irq_trigger_latch u_irq_trigger_latch (.*);

    function automatic logic [7:0] exp_pending();
        return (m_mode & m_s2) | (~m_mode & m_edge);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_edge = '0; m_mode = '0;
        m_sv = 0; m_sp = 0; m_sl = '0;
    endtask

    task automatic model_step();
        logic [7:0] rise;
        rise = m_s2 & ~m_prev;
        for (int i = 0; i < 8; i++) begin
            if (m_mode[i])                              m_edge[i] = 1'b0;
            else if (rise[i])                           m_edge[i] = 1'b1;
            else if (ack_valid && ack_level == 3'(i))   m_edge[i] = 1'b0;
        end
        m_sv = sample_strobe;
        m_sp = sample_strobe && !m_s2[sample_level];
        m_sl = !sample_strobe ? 3'd0 : (m_sp ? 3'd7 : sample_level);
        m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
        if (mode_wr_en) m_mode = mode_wr_data;
    endtask

    // One clock: update model at the edge, compare all outputs at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R3 R6 pending vs model", pending, exp_pending());
        check("R2 mode_q vs model", mode_q, m_mode);
        check("R8 R9 sample result vs model",
              {5'd0, sample_valid, sample_spurious, 1'b0} | {5'd0, 3'd0},
              {5'd0, m_sv, m_sp, 1'b0});
        check("R8 R9 sample level vs model", {5'd0, sample_level_o}, {5'd0, m_sl});
    endtask

    task automatic idle_ctl();
        mode_wr_en = 0; ack_valid = 0; sample_strobe = 0;
    endtask

    initial begin
        irq_in = '0; mode_wr_en = 0; mode_wr_data = '0; ack_valid = 0; ack_level = '0;
        sample_strobe = 0; sample_level = '0; rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 pending after reset", pending, 8'h00);
        check("R1 mode_q after reset", mode_q, 8'h00);
        check("R1 sample outputs after reset", {5'd0, sample_valid, sample_spurious, 1'b0}, 8'h00);
        check("R1 sample level after reset", {5'd0, sample_level_o}, 8'h00);

        // R3: edge on lines 2 and 5, visible after three clocks.
        irq_in = 8'h24;
        cyc(); cyc();
        check("R3 not yet pending after two clocks", pending & 8'h24, 8'h00);
        cyc();
        check("R3 edge request latched", pending & 8'h24, 8'h24);

        // R4, R5: ack level 2 while still high; line 5 untouched.
        ack_valid = 1; ack_level = 3'd2; cyc(); idle_ctl();
        cyc(); cyc(); cyc();
        check("R4 held-high line raises no new request", pending & 8'h04, 8'h00);
        check("R5 ack clears only its own line", pending & 8'h20, 8'h20);

        // R8: line 5 active at the strobe.
        sample_strobe = 1; sample_level = 3'd5; cyc(); idle_ctl();
        check("R8 active line confirmed", {4'd0, sample_valid, sample_spurious, 2'd0}, 8'h08);
        check("R8 level passed through", {5'd0, sample_level_o}, 8'h05);

        // R9: line 5 has gone low before the strobe.
        irq_in = 8'h04; cyc(); cyc(); cyc();
        sample_strobe = 1; sample_level = 3'd5; cyc(); idle_ctl();
        check("R9 spurious flagged", {4'd0, sample_valid, sample_spurious, 2'd0}, 8'h0C);
        check("R9 spurious maps to level 7", {5'd0, sample_level_o}, 8'h07);

        // R2, R6, R7: line 0 in level mode.
        mode_wr_en = 1; mode_wr_data = 8'h01; cyc(); idle_ctl();
        check("R2 mode write visible next clock", mode_q, 8'h01);
        irq_in = 8'h05; cyc(); cyc();
        check("R6 level line pending after two clocks", pending & 8'h01, 8'h01);
        ack_valid = 1; ack_level = 3'd0; cyc(); idle_ctl(); cyc();
        check("R7 level line still high stays pending", pending & 8'h01, 8'h01);
        irq_in = 8'h04; cyc(); cyc();
        check("R6 level line follows input low", pending & 8'h01, 8'h00);

        // R10: rise on line 3 coincides with ack of level 3.
        irq_in = 8'h0C; cyc(); cyc();
        ack_valid = 1; ack_level = 3'd3; cyc(); idle_ctl();
        check("R10 rise wins over same-cycle ack", pending & 8'h08, 8'h08);
        cyc();
        check("R10 request stays set after ack", pending & 8'h08, 8'h08);

        // R11: line 4 latched, passes through level mode, back to edge while still high.
        irq_in = 8'h1C; cyc(); cyc(); cyc();
        check("R3 line 4 latched", pending & 8'h10, 8'h10);
        mode_wr_en = 1; mode_wr_data = 8'h11; cyc();
        mode_wr_data = 8'h01; cyc(); idle_ctl();
        cyc(); cyc(); cyc();
        check("R11 no stale edge after level mode", pending & 8'h10, 8'h00);

        // Random phase against the model.
        void'($urandom(32'd20240607));
        for (int k = 0; k < 3000; k++) begin
            for (int b = 0; b < 8; b++)
                if (($urandom % 6) == 0) irq_in[b] = ~irq_in[b];
            mode_wr_en    = (($urandom % 40) == 0);
            mode_wr_data  = 8'($urandom);
            ack_valid     = (($urandom % 4) == 0);
            ack_level     = 3'($urandom);
            sample_strobe = (($urandom % 5) == 0);
            sample_level  = 3'($urandom);
            cyc();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule